// File: doc/BRIEF.md
# Error-Rate Mute with Hysteresis

This block watches the double-error flags produced by a block error decoder and decides whether the audio path should be muted because reception has become too poor. It counts those flags over a window made of a programmable number of frames. When a window closes with more flags than a selected fraction of the largest count that window could hold, the mute flag is raised. Once raised, the flag drops only when a later window closes with a count below half of that mute limit. A count between the two limits leaves the flag where it was, so the mute does not chatter on a marginal signal.

The largest possible count is 32 flags per frame times the window length. A 2-bit window code picks 128, 256, 512 or 1024 frames, and a 2-bit threshold code picks 1/2, 1/4, 1/8 or 1/16 of that largest count as the mute limit. An enable input switches the whole mute source off. The codes are taken into use only at window boundaries, so a window is always judged by the settings that were in force while it ran.

Top module: `err_rate_mute`

## Requirements
- R1: After synchronous reset the mute output is low and the settings in force are window code 01 (256 frames) and threshold code 01 (1/4), whatever the code inputs carry.
- R2: Window code 00 closes a window on the 128th frame strobe, 01 on the 256th, 10 on the 512th and 11 on the 1024th, counted from the start of the window.
- R3: The mute limit is (32 × window frames) shifted right by one more than the threshold code, so code 00 gives 1/2, 01 gives 1/4, 10 gives 1/8 and 11 gives 1/16 of the largest count.
- R4: When a window closes while unmuted and its flag count is strictly greater than the mute limit, the mute output goes high in the cycle after the closing frame strobe; a count equal to the limit does not mute. A flag in the same cycle as the closing strobe belongs to the closing window.
- R5: When a window closes while muted and its count is strictly below half the mute limit, the mute output goes low in the cycle after the closing strobe; a count equal to half the limit keeps the mute.
- R6: A count between the release and mute limits leaves the mute state unchanged, and the mute output never changes except after a closing strobe or a disable.
- R7: Codes presented during a window have no effect on that window; they are sampled at its closing strobe and govern the next window.
- R8: While the enable is low, the mute output goes low one cycle later, the frame and flag counts are held at zero, flags are ignored, and the codes are followed continuously so a re-enabled window starts fresh with the present codes.
- R9: The flag count saturates at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Enable for this mute source |
| frame_i | input | 1 | One-cycle pulse per received frame |
| dbl_err_i | input | 1 | One-cycle pulse per double-error detection |
| win_code_i | input | 2 | Window length code |
| thr_code_i | input | 2 | Mute threshold code |
| mute_o | output | 1 | Mute request, high while muted |

## Verification
A wrong frame count or a stale setting shows up only at window boundaries, as a mute that rises or falls one window early or late, so the bench samples the flag both in the middle of windows and one cycle after each closing strobe. Counts placed exactly on the mute limit and on half of it expose an off-by-one comparison at the first boundary after them. A wrapping flag counter appears as a missing mute after a window with more flags than the counter can hold, and a hysteresis state left set by a disable appears as a mute at the first check after re-enable.

// File: rtl/errmute_pkg.sv
package errmute_pkg;

    localparam int unsigned CODE_W             = 2;
    localparam int unsigned N_CODES            = 1 << CODE_W;
    localparam int unsigned DEF_BASE_FRAMES    = 128;
    localparam int unsigned DEF_ERRS_PER_FRAME = 32;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t win;
        code_t thr;
    } mute_cfg_t;

    localparam mute_cfg_t CFG_RESET = '{win: 2'b01, thr: 2'b01};

    typedef enum logic {
        ST_OPEN  = 1'b0,
        ST_MUTED = 1'b1
    } mute_state_t;

    // Bits needed to count the frames of the longest window.
    function automatic int unsigned frame_cnt_w(input int unsigned base);
        return $clog2(base << (N_CODES - 1));
    endfunction

    // Bits for the flag tally: largest window count plus one bit of headroom.
    function automatic int unsigned tally_w(input int unsigned base,
                                            input int unsigned per_frame);
        return $clog2(per_frame * (base << (N_CODES - 1))) + 1;
    endfunction

    // Right shift that turns the largest count into the mute limit.
    function automatic logic [4:0] limit_shift(input code_t thr);
        return 5'(thr) + 5'd1;
    endfunction

endpackage

// File: rtl/emute_cfg_hold.sv
module emute_cfg_hold
    import errmute_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      en_i,
    input  logic      win_end_i,
    input  code_t     win_code_i,
    input  code_t     thr_code_i,
    output mute_cfg_t cfg_o
);

    mute_cfg_t cfg_q;

    // Settings move only at a boundary, or continuously while disabled.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q <= CFG_RESET;
        end else if (!en_i || win_end_i) begin
            cfg_q <= '{win: win_code_i, thr: thr_code_i};
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/emute_frame_win.sv
module emute_frame_win
    import errmute_pkg::*;
#(
    parameter int unsigned BASE_FRAMES = DEF_BASE_FRAMES,
    parameter int unsigned FCNT_W      = frame_cnt_w(DEF_BASE_FRAMES)
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  en_i,
    input  logic  frame_i,
    input  code_t win_i,
    output logic  win_end_o
);

    logic [FCNT_W-1:0] last_tab [N_CODES];
    logic [FCNT_W-1:0] cnt_q;

    // Index of the final frame of each window length.
    for (genvar g = 0; g < N_CODES; g++) begin : g_last
        assign last_tab[g] = FCNT_W'((BASE_FRAMES << g) - 1);
    end

    assign win_end_o = en_i && frame_i && (cnt_q == last_tab[win_i]);

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
            cnt_q <= '0;
        end else if (win_end_o) begin
            cnt_q <= '0;
        end else if (frame_i) begin
            cnt_q <= cnt_q + FCNT_W'(1);
        end
    end

endmodule

// File: rtl/emute_err_acc.sv
module emute_err_acc #(
    parameter int unsigned TALLY_W = 16
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               en_i,
    input  logic               err_i,
    input  logic               win_end_i,
    output logic [TALLY_W-1:0] tally_o,
    output logic [TALLY_W-1:0] cnt_o
);

    logic [TALLY_W-1:0] cnt_q;
    logic               at_top;

    assign at_top  = &cnt_q;
    // Tally including a flag in this cycle, saturated at all ones.
    assign tally_o = (err_i && !at_top) ? cnt_q + TALLY_W'(1) : cnt_q;
    assign cnt_o   = cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i || win_end_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= tally_o;
        end
    end

endmodule

// File: rtl/emute_verdict.sv
module emute_verdict
    import errmute_pkg::*;
#(
    parameter int unsigned BASE_FRAMES   = DEF_BASE_FRAMES,
    parameter int unsigned ERRS_PER_FRAME = DEF_ERRS_PER_FRAME,
    parameter int unsigned TALLY_W       = 16
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               en_i,
    input  logic               win_end_i,
    input  mute_cfg_t          cfg_i,
    input  logic [TALLY_W-1:0] tally_i,
    output logic               mute_o
);

    logic [TALLY_W-1:0] full_tab [N_CODES];
    logic [TALLY_W-1:0] mute_lim;
    logic [TALLY_W-1:0] rel_lim;
    mute_state_t        state_q;
    mute_state_t        state_d;

    // Largest count each window length can hold.
    for (genvar g = 0; g < N_CODES; g++) begin : g_full
        assign full_tab[g] = TALLY_W'(ERRS_PER_FRAME * (BASE_FRAMES << g));
    end

    assign mute_lim = full_tab[cfg_i.win] >> limit_shift(cfg_i.thr);
    assign rel_lim  = mute_lim >> 1;

    always_comb begin
        state_d = state_q;
        if (win_end_i) begin
            unique case (state_q)
                ST_OPEN:  if (tally_i > mute_lim) state_d = ST_MUTED;
                ST_MUTED: if (tally_i < rel_lim)  state_d = ST_OPEN;
                default:  state_d = ST_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
            state_q <= ST_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    assign mute_o = (state_q == ST_MUTED);

endmodule

// File: rtl/err_rate_mute.sv
module err_rate_mute
    import errmute_pkg::*;
#(
    parameter int unsigned BASE_FRAMES    = DEF_BASE_FRAMES,
    parameter int unsigned ERRS_PER_FRAME = DEF_ERRS_PER_FRAME
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       en_i,
    input  logic       frame_i,
    input  logic       dbl_err_i,
    input  logic [1:0] win_code_i,
    input  logic [1:0] thr_code_i,
    output logic       mute_o
);

    localparam int unsigned FCNT_W  = frame_cnt_w(BASE_FRAMES);
    localparam int unsigned TALLY_W = tally_w(BASE_FRAMES, ERRS_PER_FRAME);

    mute_cfg_t          cfg_act;
    logic               win_end;
    logic [TALLY_W-1:0] tally;
    logic [TALLY_W-1:0] acc_cnt;

    emute_cfg_hold u_cfg (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .en_i       (en_i),
        .win_end_i  (win_end),
        .win_code_i (win_code_i),
        .thr_code_i (thr_code_i),
        .cfg_o      (cfg_act)
    );

    emute_frame_win #(
        .BASE_FRAMES (BASE_FRAMES),
        .FCNT_W      (FCNT_W)
    ) u_win (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .en_i      (en_i),
        .frame_i   (frame_i),
        .win_i     (cfg_act.win),
        .win_end_o (win_end)
    );

    emute_err_acc #(
        .TALLY_W (TALLY_W)
    ) u_acc (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .en_i      (en_i),
        .err_i     (dbl_err_i),
        .win_end_i (win_end),
        .tally_o   (tally),
        .cnt_o     (acc_cnt)
    );

    emute_verdict #(
        .BASE_FRAMES    (BASE_FRAMES),
        .ERRS_PER_FRAME (ERRS_PER_FRAME),
        .TALLY_W        (TALLY_W)
    ) u_verdict (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .en_i      (en_i),
        .win_end_i (win_end),
        .cfg_i     (cfg_act),
        .tally_i   (tally),
        .mute_o    (mute_o)
    );

endmodule

// File: rtl/emute_checker.sv
module emute_checker #(
    parameter int unsigned TALLY_W = 16
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               en_i,
    input logic               win_end,
    input logic [3:0]         cfg_bits,
    input logic [TALLY_W-1:0] acc_cnt,
    input logic               mute_o
);

    assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !mute_o);

    assert_disable_forces_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> !mute_o);

    assert_rise_at_window_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(mute_o) |-> $past(win_end && en_i));

    assert_fall_cause_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(mute_o) |-> $past(win_end || !en_i));

    assert_hold_midwindow_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !win_end) |=> $stable(mute_o));

    assert_cfg_steady_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !win_end) |=> $stable(cfg_bits));

    assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !win_end) |=> (acc_cnt >= $past(acc_cnt)));

endmodule

bind err_rate_mute emute_checker #(
    .TALLY_W (TALLY_W)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .en_i     (en_i),
    .win_end  (win_end),
    .cfg_bits (cfg_act),
    .acc_cnt  (acc_cnt),
    .mute_o   (mute_o)
);

// File: tb/sim_err_rate_mute.sv
module sim_err_rate_mute;

    logic       clk = 1'b0;
    logic       rst_s;
    logic       en_s;
    logic       frame_s;
    logic       err_s;
    logic [1:0] win_s;
    logic [1:0] thr_s;
    logic       mute;

    int tests_run = 0;
    int tests_bad = 0;
    int cycles    = 0;
    bit done      = 1'b0;

    typedef struct {
        bit    val;
        string tag;
    } exp_item_t;

    exp_item_t sb_q [$];

    localparam int WATCHDOG = 180000;

    always #10 clk = ~clk;

    err_rate_mute u0 (
        .clk_i      (clk),
        .rst_i      (rst_s),
        .en_i       (en_s),
        .frame_i    (frame_s),
        .dbl_err_i  (err_s),
        .win_code_i (win_s),
        .thr_code_i (thr_s),
        .mute_o     (mute)
    );

    // Driver side: queue the expected mute value for this moment.
    task automatic expect_mute(input bit v, input string tag);
        exp_item_t it;
        it.val = v;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Frames of given period; flags on the first nerr cycles; ends on an idle negedge.
    task automatic run_frames(input int nframes, input int nerr, input int period);
        for (int i = 0; i < nframes * period; i++) begin
            @(negedge clk);
            frame_s = ((i % period) == period - 1);
            err_s   = (i < nerr);
        end
        @(negedge clk);
        frame_s = 1'b0;
        err_s   = 1'b0;
    endtask

    // Monitor: pop and compare as soon as an expectation appears.
    initial begin
        forever begin
            exp_item_t it;
            wait (sb_q.size() > 0);
            it = sb_q.pop_front();
            tests_run++;
            if (mute !== it.val) begin
                tests_bad++;
                $display("FAIL %s: mute actual %0b expected %0b", it.tag, mute, it.val);
            end
        end
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                tests_run++;
                tests_bad++;
                $display("FAIL watchdog: actual cycles %0d expected below %0d", cycles, WATCHDOG);
                $display("  [TB] %0d tests run, %0d failed", tests_run, tests_bad);
                $finish;
            end
        end
    end

    initial begin
        rst_s   = 1'b1;
        en_s    = 1'b1;
        frame_s = 1'b0;
        err_s   = 1'b0;
        win_s   = 2'b00;
        thr_s   = 2'b00;
        repeat (4) @(negedge clk);
        rst_s = 1'b0;
        @(negedge clk);
        expect_mute(1'b0, "R1 reset state");

        // Reset settings 01/01: 256 frames, limit 2048, release 1024.
        run_frames(128, 1280, 10);
        expect_mute(1'b0, "R1 mid first window");
        run_frames(128, 769, 10);
        expect_mute(1'b1, "R1 R4 2049 over 2048 after 256 frames");

        // Now 00/00: 128 frames, limit 2048, release 1024.
        run_frames(128, 1024, 10);
        expect_mute(1'b1, "R5 count equal to release keeps mute");
        run_frames(128, 1023, 10);
        expect_mute(1'b0, "R5 count below release clears");
        run_frames(128, 2048, 20);
        expect_mute(1'b0, "R4 count equal to limit no mute");
        run_frames(128, 1500, 20);
        expect_mute(1'b0, "R6 between limits stays open");

        win_s = 2'b00;
        thr_s = 2'b11;
        run_frames(128, 300, 10);
        expect_mute(1'b0, "R7 new threshold not used in current window");

        // 00/11: 128 frames, limit 256, release 128.
        run_frames(128, 257, 4);
        expect_mute(1'b1, "R3 R4 257 over 1/16 limit");
        win_s = 2'b01;
        thr_s = 2'b11;
        run_frames(128, 200, 4);
        expect_mute(1'b1, "R6 between limits stays muted");

        // 01/11: 256 frames, limit 512, release 256.
        run_frames(128, 0, 4);
        expect_mute(1'b1, "R7 R2 window not yet closed at 128 frames");
        run_frames(128, 255, 4);
        expect_mute(1'b0, "R5 release after 256 frames");
        run_frames(256, 600, 4);
        expect_mute(1'b1, "R4 600 over 512");

        en_s = 1'b0;
        @(negedge clk);
        expect_mute(1'b0, "R8 disable clears mute");
        run_frames(40, 200, 4);
        expect_mute(1'b0, "R8 flags ignored while disabled");
        en_s  = 1'b1;
        win_s = 2'b00;
        thr_s = 2'b11;
        run_frames(256, 500, 4);
        expect_mute(1'b0, "R8 fresh window after enable");

        // 00/11 again: saturation check.
        run_frames(128, 65546, 513);
        expect_mute(1'b1, "R9 tally saturates instead of wrapping");
        win_s = 2'b11;
        thr_s = 2'b00;
        run_frames(128, 100, 4);
        expect_mute(1'b0, "R5 100 below 128");

        // 11/00: 1024 frames, limit 16384, release 8192.
        run_frames(600, 16385, 28);
        expect_mute(1'b0, "R2 long window still open");
        run_frames(424, 0, 4);
        expect_mute(1'b1, "R2 R3 mute after 1024 frames");
        run_frames(1024, 8191, 17);
        expect_mute(1'b0, "R5 release on longest window");

        wait (sb_q.size() == 0);
        #1;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_bad);
        $finish;
    end

endmodule